// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that runs its external bus in maximum mode and reports each bus cycle only as a three-bit status code. It watches that code, recognises the start of every bus cycle, and turns the code into separate active-high command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces early versions of the two write strobes, which give slow devices an extra clock of access time.

Alongside the commands it drives the controls for the external parts of the bus. An address-latch strobe captures the multiplexed address. A data-enable output and a direction output steer the bidirectional data transceiver. Two gating inputs can hold the command strobes off while another master owns the bus. A mode input marks the I/O side as a private bus that no other master can take.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released with `status` = 3'b111, every output is 0.
- R2: A cycle starts on the first clock edge that samples a status other than 3'b111 after one that sampled 3'b111. `ale` is 1 for exactly that first clock of the cycle and 0 otherwise.
- R3: Status encoding, latched at cycle start: 3'b000 interrupt acknowledge (`int_ack`), 3'b001 I/O read (`io_rd`), 3'b010 I/O write (`io_wr`), 3'b011 halt, 3'b100 code fetch (`mem_rd`), 3'b101 memory read (`mem_rd`), 3'b110 memory write (`mem_wr`), 3'b111 passive.
- R4: Read-type commands (`mem_rd`, `io_rd`, `int_ack`) assert from the second clock of the cycle and are never active while `ale` is 1.
- R5: `adv_mem_wr` and `adv_io_wr` assert from the second clock of a write cycle. `mem_wr` and `io_wr` assert one clock later, from the third clock.
- R6: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` and `int_ack` is 1 in any clock.
- R7: Every command output is 0 in the clock after an edge that samples status 3'b111.
- R8: Halt cycles drive no command, but `ale` still pulses.
- R9: With `io_bus_mode` = 0, every command output is 0 whenever `addr_en` or `cmd_en` is 0.
- R10: With `io_bus_mode` = 1, the I/O commands and `int_ack` ignore `addr_en` and `cmd_en`. The memory commands are still gated as in R9.
- R11: `den` is 1 from the second clock of any non-halt cycle until the cycle ends. `dt_r` is 1 for the whole of a write cycle (codes 3'b010 and 3'b110) and 0 otherwise.
- R12: A status that changes from one active code to another without passing through 3'b111 starts no new cycle. The latched cycle type is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 3 | Encoded bus-cycle type from the processor |
| cmd_en | input | 1 | Command enable; 0 holds gated commands off |
| addr_en | input | 1 | Address enable; 0 models a released bus |
| io_bus_mode | input | 1 | 1 = I/O commands belong to a private bus |
| ale | output | 1 | Address latch enable pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Data direction, 1 = transmit (write) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| adv_mem_wr | output | 1 | Early memory write command |
| adv_io_wr | output | 1 | Early I/O write command |

## Verification
The assertions watch the timing invariants on every clock. These are the exclusivity of the five commands, the single-clock address strobe, commands held off during that strobe, an early write always one clock ahead of its normal write, silence after a passive sample, silence in halt cycles, and the gating from address enable. Only the bench's scenarios can show that each status code produces the correct command, direction and data enable in the correct clock. A sweep over every code and every combination of `cmd_en`, `addr_en` and `io_bus_mode` covers this. The same holds for the rule that a change between active codes does not restart a cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int STATUS_W = 3;

  typedef enum logic [STATUS_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACCESS,
    PH_LATE
  } phase_e;

  typedef struct packed {
    logic int_ack;
    logic io_rd;
    logic io_wr;
    logic mem_rd;
    logic mem_wr;
  } cmd_t;

  // Cycle type to command bits (R3)
  function automatic cmd_t decode_status(input status_e s);
    cmd_t c;
    c = '0;
    case (s)
      ST_INTA:            c.int_ack = 1'b1;
      ST_IORD:            c.io_rd   = 1'b1;
      ST_IOWR:            c.io_wr   = 1'b1;
      ST_FETCH, ST_MRD:   c.mem_rd  = 1'b1;
      ST_MWR:             c.mem_wr  = 1'b1;
      default:            c = '0;
    endcase
    return c;
  endfunction

  function automatic logic is_write(input status_e s);
    return (s == ST_IOWR) || (s == ST_MWR);
  endfunction

endpackage

// File: rtl/bcg_cycle_track.sv
module bcg_cycle_track
  import bcg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] status,
  output phase_e              phase,
  output status_e             code
);

  logic    last_passive;
  status_e st_in;
  logic    now_passive;
  logic    start_evt;

  assign st_in       = status_e'(status);
  assign now_passive = (st_in == ST_PASSIVE);
  assign start_evt   = !now_passive && last_passive && (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      code         <= ST_PASSIVE;
      last_passive <= 1'b1;
    end else begin
      last_passive <= now_passive;
      if (now_passive) begin
        phase <= PH_IDLE;
      end else if (start_evt) begin
        phase <= PH_ADDR;
        code  <= st_in;
      end else begin
        case (phase)
          PH_ADDR:   phase <= PH_ACCESS;
          PH_ACCESS: phase <= PH_LATE;
          default:   phase <= phase;
        endcase
      end
    end
  end

endmodule

// File: rtl/bcg_strobe_dec.sv
module bcg_strobe_dec
  import bcg_pkg::*;
(
  input  phase_e  phase,
  input  status_e code,
  output cmd_t    raw_cmd,
  output logic    raw_adv_mem,
  output logic    raw_adv_io,
  output logic    ale_o,
  output logic    den_o,
  output logic    dtr_o
);

  cmd_t dec;
  logic in_cycle;
  logic data_ph;
  logic late_ph;

  assign dec      = decode_status(code);
  assign in_cycle = (phase != PH_IDLE);
  assign data_ph  = (phase == PH_ACCESS) || (phase == PH_LATE);
  assign late_ph  = (phase == PH_LATE);

  always_comb begin
    raw_cmd.int_ack = data_ph & dec.int_ack;
    raw_cmd.io_rd   = data_ph & dec.io_rd;
    raw_cmd.mem_rd  = data_ph & dec.mem_rd;
    raw_cmd.io_wr   = late_ph & dec.io_wr;
    raw_cmd.mem_wr  = late_ph & dec.mem_wr;
  end

  assign raw_adv_mem = data_ph & dec.mem_wr;
  assign raw_adv_io  = data_ph & dec.io_wr;
  assign ale_o       = (phase == PH_ADDR);
  assign den_o       = data_ph && (code != ST_HALT);
  assign dtr_o       = in_cycle && is_write(code);

endmodule

// File: rtl/bcg_out_gate.sv
module bcg_out_gate
  import bcg_pkg::*;
(
  input  cmd_t raw_cmd,
  input  logic raw_adv_mem,
  input  logic raw_adv_io,
  input  logic cmd_en,
  input  logic addr_en,
  input  logic io_bus_mode,
  output cmd_t cmd_o,
  output logic adv_mem_o,
  output logic adv_io_o
);

  logic mem_ok;
  logic io_ok;

  assign mem_ok = cmd_en & addr_en;
  assign io_ok  = io_bus_mode | mem_ok;

  always_comb begin
    cmd_o.mem_rd  = raw_cmd.mem_rd  & mem_ok;
    cmd_o.mem_wr  = raw_cmd.mem_wr  & mem_ok;
    cmd_o.io_rd   = raw_cmd.io_rd   & io_ok;
    cmd_o.io_wr   = raw_cmd.io_wr   & io_ok;
    cmd_o.int_ack = raw_cmd.int_ack & io_ok;
  end

  assign adv_mem_o = raw_adv_mem & mem_ok;
  assign adv_io_o  = raw_adv_io  & io_ok;

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] status,
  input  logic                cmd_en,
  input  logic                addr_en,
  input  logic                io_bus_mode,
  output logic                ale,
  output logic                den,
  output logic                dt_r,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                io_rd,
  output logic                io_wr,
  output logic                int_ack,
  output logic                adv_mem_wr,
  output logic                adv_io_wr
);

  phase_e  cyc_phase;
  status_e cyc_code;
  cmd_t    raw_cmd;
  logic    raw_adv_mem;
  logic    raw_adv_io;
  cmd_t    gated_cmd;

  bcg_cycle_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .phase  (cyc_phase),
    .code   (cyc_code)
  );

  bcg_strobe_dec u_dec (
    .phase       (cyc_phase),
    .code        (cyc_code),
    .raw_cmd     (raw_cmd),
    .raw_adv_mem (raw_adv_mem),
    .raw_adv_io  (raw_adv_io),
    .ale_o       (ale),
    .den_o       (den),
    .dtr_o       (dt_r)
  );

  bcg_out_gate u_gate (
    .raw_cmd     (raw_cmd),
    .raw_adv_mem (raw_adv_mem),
    .raw_adv_io  (raw_adv_io),
    .cmd_en      (cmd_en),
    .addr_en     (addr_en),
    .io_bus_mode (io_bus_mode),
    .cmd_o       (gated_cmd),
    .adv_mem_o   (adv_mem_wr),
    .adv_io_o    (adv_io_wr)
  );

  assign mem_rd  = gated_cmd.mem_rd;
  assign mem_wr  = gated_cmd.mem_wr;
  assign io_rd   = gated_cmd.io_rd;
  assign io_wr   = gated_cmd.io_wr;
  assign int_ack = gated_cmd.int_ack;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [STATUS_W-1:0] status,
  input logic                addr_en,
  input logic                io_bus_mode,
  input logic                ale,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic                io_rd,
  input logic                io_wr,
  input logic                int_ack,
  input logic                adv_mem_wr,
  input logic                adv_io_wr,
  input cmd_t                raw_cmd,
  input logic                raw_adv_mem,
  input logic                raw_adv_io,
  input phase_e              cyc_phase,
  input status_e             cyc_code
);

  logic any_cmd;
  logic any_raw;
  assign any_cmd = mem_rd | mem_wr | io_rd | io_wr | int_ack | adv_mem_wr | adv_io_wr;
  assign any_raw = (|raw_cmd) | raw_adv_mem | raw_adv_io;

  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_no_cmd_in_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !any_raw);

  assert_mem_wr_after_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_cmd.mem_wr |-> $past(raw_adv_mem));

  assert_io_wr_after_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_cmd.io_wr |-> $past(raw_adv_io));

  assert_passive_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_PASSIVE) |=> !any_cmd);

  assert_halt_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_phase != PH_IDLE && cyc_code == ST_HALT) |-> !any_raw);

  assert_addr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_en && !io_bus_mode) |-> !any_cmd);

endmodule

bind bus_cmd_gen bcg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status      (status),
  .addr_en     (addr_en),
  .io_bus_mode (io_bus_mode),
  .ale         (ale),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .int_ack     (int_ack),
  .adv_mem_wr  (adv_mem_wr),
  .adv_io_wr   (adv_io_wr),
  .raw_cmd     (raw_cmd),
  .raw_adv_mem (raw_adv_mem),
  .raw_adv_io  (raw_adv_io),
  .cyc_phase   (cyc_phase),
  .cyc_code    (cyc_code)
);

// File: tb/bus_cmd_gen_test.sv
`timescale 1ns/1ps
module bus_cmd_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic       cmd_en = 1'b1;
  logic       addr_en = 1'b1;
  logic       io_bus_mode = 1'b0;
  logic ale, den, dt_r, mem_rd, mem_wr, io_rd, io_wr, int_ack, adv_mem_wr, adv_io_wr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst_n(rst_n), .status(status), .cmd_en(cmd_en), .addr_en(addr_en),
    .io_bus_mode(io_bus_mode), .ale(ale), .den(den), .dt_r(dt_r), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .int_ack(int_ack),
    .adv_mem_wr(adv_mem_wr), .adv_io_wr(adv_io_wr)
  );

  // {ale,den,dt_r,int_ack,io_rd,io_wr,mem_rd,mem_wr,adv_mem_wr,adv_io_wr}
  function automatic logic [9:0] outs();
    return {ale, den, dt_r, int_ack, io_rd, io_wr, mem_rd, mem_wr, adv_mem_wr, adv_io_wr};
  endfunction

  // k = clocks into the cycle: 0 idle, 1 address clock, 2 access, 3+ late
  function automatic logic [9:0] model(int code, int k, logic ce, logic ae, logic iob);
    logic is_mem, is_io_side, rd, wr, gate_m, gate_i, g;
    logic [9:0] r;
    r = '0;
    if (k == 0 || code == 7) return r;
    is_mem     = (code >= 4);
    is_io_side = (code <= 2);
    rd = (code == 0) || (code == 1) || (code == 4) || (code == 5);
    wr = (code == 2) || (code == 6);
    gate_m = ce && ae;
    gate_i = iob || gate_m;
    g = is_mem ? gate_m : (is_io_side ? gate_i : 1'b0);
    r[9] = (k == 1);                                      // ale
    r[8] = (k >= 2) && (code != 3);                       // den
    r[7] = wr;                                            // dt_r
    r[6] = (k >= 2) && g && (code == 0);                  // int_ack
    r[5] = (k >= 2) && g && (code == 1);                  // io_rd
    r[4] = (k >= 3) && g && (code == 2);                  // io_wr
    r[3] = (k >= 2) && g && rd && is_mem;                 // mem_rd
    r[2] = (k >= 3) && g && (code == 6);                  // mem_wr
    r[1] = (k >= 2) && g && (code == 6);                  // adv_mem_wr
    r[0] = (k >= 2) && g && (code == 2);                  // adv_io_wr
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [9:0] exp);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b (status=%0d ce=%b ae=%b iob=%b)",
               req, outs(), exp, status, cmd_en, addr_en, io_bus_mode);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #13;
    check("R1 in reset", 10'b0);
    rst_n = 1'b1;
    step();
    check("R1 after reset", 10'b0);

    // Sweep codes x enables x mode: R2 R3 R4 R5 R7 R8 R9 R10 R11
    for (int code = 0; code < 8; code++) begin
      for (int e = 0; e < 8; e++) begin
        cmd_en = e[0]; addr_en = e[1]; io_bus_mode = e[2];
        status = 3'b111;
        step();
        check("R7 idle before cycle", 10'b0);
        status = code[2:0];
        for (int k = 1; k <= 4; k++) begin
          step();
          check("R3_R5_R9_R10_R11 cycle", model(code, k, e[0], e[1], e[2]));
        end
        status = 3'b111;
        step();
        check("R7 passive clears", 10'b0);
      end
    end

    // R8 halt still pulses ale
    cmd_en = 1'b1; addr_en = 1'b1; io_bus_mode = 1'b0;
    status = 3'b011;
    step();
    check("R8 halt ale", 10'b1000000000);
    step();
    check("R8 halt silent", 10'b0);
    status = 3'b111;
    step();

    // R12 active-to-active change keeps latched type, no new ale
    status = 3'b101;
    step();
    check("R12 start", model(5, 1, 1'b1, 1'b1, 1'b0));
    status = 3'b001;
    step();
    check("R12 no restart", model(5, 2, 1'b1, 1'b1, 1'b0));
    status = 3'b110;
    step();
    check("R12 type kept", model(5, 3, 1'b1, 1'b1, 1'b0));
    status = 3'b111;
    step();
    check("R7 end", 10'b0);

    // R6 read/write exclusivity after back-to-back cycles with one idle
    status = 3'b110;
    step(); step(); step();
    check("R6 mem write only", model(6, 3, 1'b1, 1'b1, 1'b0));
    status = 3'b111;
    step();
    status = 3'b000;
    step(); step();
    check("R6 int_ack only", model(0, 2, 1'b1, 1'b1, 1'b0));
    status = 3'b111;
    step();
    check("R7 final", 10'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule